// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt request lines is served. Requests are looked at only when the core signals an instruction boundary. At that point the block applies a global enable flag and a mask bit for each of the three hard-vectored maskable lines, then picks the highest-priority request that survives. For a hard-vectored winner it presents a fixed 16-bit vector together with a one-cycle request for the core to push its program counter.

The lowest-priority line, the general request, has no fixed vector. When it wins, the block runs acknowledge strobes on its own and reads an opcode from the data bus. A restart opcode gives a vector of eight times its 3-bit field. A three-byte call opcode makes the block strobe twice more and take the target from the next two bytes, low byte first. Any other opcode ends the sequence with no vector. The stack write and the fetch of code at the vector belong to the core.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset no strobe, vector or push request is active, `vec_addr` is 0, the global enable is off and all three per-line mask bits are set.
- R2: Priority from highest to lowest is the non-maskable line, then `irq_l7`, `irq_l6`, `irq_l5`, and last `irq_general`. Only one request is served per boundary.
- R3: The hard-wired vectors are 0x0024 for the non-maskable line, 0x003C for `irq_l7`, 0x0034 for `irq_l6` and 0x002C for `irq_l5`.
- R4: The non-maskable line is served whatever the enable and masks hold. It needs a rising edge, and the line must still be high at the boundary. Once served, it needs a new rising edge before it is served again.
- R5: `ie_set` turns the global enable on and `ie_clr` turns it off. If both arrive in one cycle, off wins. When the enable is off, every maskable line is blocked. Accepting any maskable request clears the enable. Accepting the non-maskable request leaves it unchanged.
- R6: A pulse on `mask_wr` loads `mask_data`. Bit 0 masks `irq_l5`, bit 1 masks `irq_l6` and bit 2 masks `irq_l7`, and a 1 blocks the line.
- R7: A rising edge on `irq_l7` is latched even if the pulse ends before the boundary. A mask does not clear the latch, so the request is served once it is unmasked. Serving it clears the latch.
- R8: When `irq_general` wins, `inta` pulses for one cycle, starting the cycle after the boundary. The byte on `bus_data` in that cycle is taken as the opcode. An opcode of the form 11nnn111 gives vector nnn*8, with exactly one strobe.
- R9: If the opcode is 0xCD, `inta` pulses twice more with one idle cycle before each pulse. The byte read during the second strobe is the low address byte and the byte read during the third is the high byte, so there are three strobes in total.
- R10: Any opcode that is neither a restart nor 0xCD produces no vector and no push request.
- R11: `vec_valid` and `push_pc` are high together for exactly one cycle. This is the cycle after the boundary for a hard-wired vector, the cycle after the single strobe for a restart, and the cycle after the third strobe for a call.
- R12: Requests present while `instr_boundary` is low are never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_boundary | input | 1 | Core is at an instruction boundary |
| ie_set | input | 1 | Turn global enable on |
| ie_clr | input | 1 | Turn global enable off |
| mask_wr | input | 1 | Load per-line masks |
| mask_data | input | 3 | New mask bits (1 = blocked) |
| irq_general | input | 1 | General request, level |
| irq_l5 | input | 1 | Level request, vector 0x002C |
| irq_l6 | input | 1 | Level request, vector 0x0034 |
| irq_l7 | input | 1 | Edge request, vector 0x003C |
| irq_nmi | input | 1 | Non-maskable request, edge and level |
| bus_data | input | 8 | Opcode and address bytes during acknowledge |
| inta | output | 1 | Acknowledge strobe |
| vec_valid | output | 1 | Vector address is valid |
| vec_addr | output | 16 | Branch target |
| push_pc | output | 1 | Core must push its program counter |

## Verification
The assertions assume that `instr_boundary` is pulsed only when the block is idle and no vector is being issued. They also assume that the bus byte is stable in each cycle where `inta` is high. The stimulus meets both conditions. Each trial gives a single one-cycle boundary pulse, then waits out the longest acknowledge sequence before the next trial starts. Bus bytes change only on the falling clock edge while a strobe is high. Request lines, mask writes and enable pulses are set two cycles before the boundary, so the edge latches have settled.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned N_HW   = 3;          // hard-vectored maskable lines
    localparam int unsigned N_SRC  = N_HW + 2;   // plus general and non-maskable

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_INTR = 3'd1,
        SRC_L5   = 3'd2,
        SRC_L6   = 3'd3,
        SRC_L7   = 3'd4,
        SRC_TRAP = 3'd5
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } grant_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OP, ST_GAP_LO, ST_LO, ST_GAP_HI, ST_HI
    } ack_st_e;

    localparam logic [DATA_W-1:0] OP_CALL  = 8'hCD;
    localparam logic [DATA_W-1:0] RST_FORM = 8'hC7;

    function automatic logic [ADDR_W-1:0] hw_vector(src_e s);
        logic [ADDR_W-1:0] v;
        case (s)
            SRC_TRAP: v = 16'h0024;
            SRC_L7:   v = 16'h003C;
            SRC_L6:   v = 16'h0034;
            SRC_L5:   v = 16'h002C;
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic logic is_restart(logic [DATA_W-1:0] op);
        return (op & RST_FORM) == RST_FORM;
    endfunction

    function automatic logic [ADDR_W-1:0] restart_vector(logic [DATA_W-1:0] op);
        return ADDR_W'({op[5:3], 3'b000});
    endfunction
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic line,
    input  logic clear,
    output logic pend
);
    logic line_q;
    logic lat_q;
    logic rise;
    logic keep;

    assign rise = line & ~line_q;

    generate
        if (HOLD_LEVEL) begin : g_hold
            assign keep = line;
            assign pend = lat_q & line;

            // R4
            drop_kills_chk: assert property (@(posedge clk) disable iff (rst)
                !line |-> !pend);
        end else begin : g_sticky
            assign keep = 1'b1;
            assign pend = lat_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            line_q <= line;
            lat_q  <= rise | (lat_q & keep & ~clear);
        end
    end

    // R7
    rise_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line) |=> lat_q);
endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            nmi_pend,
    input  logic            l7_pend,
    input  logic            lvl6,
    input  logic            lvl5,
    input  logic            gen_req,
    input  logic            glb_en,
    input  logic [N_HW-1:0] hw_mask,
    output grant_t          grant
);
    logic [N_SRC-1:0] req;
    logic [N_HW-1:0]  hw_line;

    assign hw_line  = {l7_pend, lvl6, lvl5};
    assign req[0]   = glb_en & gen_req;
    assign req[N_SRC-1] = nmi_pend;

    generate
        for (genvar g = 0; g < N_HW; g++) begin : g_hw
            assign req[g+1] = glb_en & hw_line[g] & ~hw_mask[g];
        end
    endgenerate

    always_comb begin
        grant = '{valid: 1'b0, src: SRC_NONE};
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i]) grant = '{valid: 1'b1, src: src_e'(3'(i + 1))};
        end
    end

    // R4
    trap_first_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (grant.valid && grant.src == SRC_TRAP));

    // R5
    ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!glb_en && !nmi_pend) |-> !grant.valid);

    // R6
    masked_l5_chk: assert property (@(posedge clk) disable iff (rst)
        hw_mask[0] |-> !(grant.valid && grant.src == SRC_L5));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  grant_t            grant,
    input  logic [DATA_W-1:0] bus_data,
    output logic              accept,
    output logic              inta,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr
);
    ack_st_e           st;
    logic              inta_q;
    logic              vec_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] lo_q;

    assign accept    = boundary && grant.valid && (st == ST_IDLE);
    assign inta      = inta_q;
    assign vec_valid = vec_q;
    assign vec_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            inta_q <= 1'b0;
            vec_q  <= 1'b0;
            addr_q <= '0;
            lo_q   <= '0;
        end else begin
            inta_q <= 1'b0;
            vec_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        if (grant.src == SRC_INTR) begin
                            st     <= ST_OP;
                            inta_q <= 1'b1;
                        end else begin
                            vec_q  <= 1'b1;
                            addr_q <= hw_vector(grant.src);
                        end
                    end
                end
                ST_OP: begin
                    if (is_restart(bus_data)) begin
                        vec_q  <= 1'b1;
                        addr_q <= restart_vector(bus_data);
                        st     <= ST_IDLE;
                    end else if (bus_data == OP_CALL) begin
                        st <= ST_GAP_LO;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_GAP_LO: begin
                    inta_q <= 1'b1;
                    st     <= ST_LO;
                end
                ST_LO: begin
                    lo_q <= bus_data;
                    st   <= ST_GAP_HI;
                end
                ST_GAP_HI: begin
                    inta_q <= 1'b1;
                    st     <= ST_HI;
                end
                ST_HI: begin
                    vec_q  <= 1'b1;
                    addr_q <= ADDR_W'({bus_data, lo_q});
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9
    inta_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        inta_q |=> !inta_q);

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(inta_q && vec_q));

    // R8
    restart_align_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_q && $past(st == ST_OP)) |-> (addr_q[2:0] == 3'b000));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_boundary,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              mask_wr,
    input  logic [N_HW-1:0]   mask_data,
    input  logic              irq_general,
    input  logic              irq_l5,
    input  logic              irq_l6,
    input  logic              irq_l7,
    input  logic              irq_nmi,
    input  logic [DATA_W-1:0] bus_data,
    output logic              inta,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              push_pc
);
    logic            ie_q;
    logic [N_HW-1:0] mask_q;
    logic            nmi_pend;
    logic            l7_pend;
    logic            accept;
    logic            clr_nmi;
    logic            clr_l7;
    grant_t          grant;

    assign clr_nmi = accept && grant.src == SRC_TRAP;
    assign clr_l7  = accept && grant.src == SRC_L7;

    irq_edge_capture #(.HOLD_LEVEL(1'b1)) u_nmi_cap (
        .clk(clk), .rst(rst), .line(irq_nmi), .clear(clr_nmi), .pend(nmi_pend)
    );

    irq_edge_capture #(.HOLD_LEVEL(1'b0)) u_l7_cap (
        .clk(clk), .rst(rst), .line(irq_l7), .clear(clr_l7), .pend(l7_pend)
    );

    irq_priority_sel u_sel (
        .clk(clk), .rst(rst),
        .nmi_pend(nmi_pend), .l7_pend(l7_pend), .lvl6(irq_l6), .lvl5(irq_l5),
        .gen_req(irq_general), .glb_en(ie_q), .hw_mask(mask_q), .grant(grant)
    );

    irq_ack_seq u_seq (
        .clk(clk), .rst(rst), .boundary(instr_boundary), .grant(grant),
        .bus_data(bus_data), .accept(accept), .inta(inta),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    assign push_pc = vec_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
        end else begin
            if (ie_clr || (accept && grant.src != SRC_TRAP)) ie_q <= 1'b0;
            else if (ie_set)                                  ie_q <= 1'b1;
            if (mask_wr) mask_q <= mask_data;
        end
    end

    // R5
    ie_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && grant.src != SRC_TRAP) |=> !ie_q);

    // R12
    boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!instr_boundary && !vec_valid && !inta && $past(!instr_boundary)
         && !$past(inta)) |=> !vec_valid);
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, instr_boundary, ie_set, ie_clr, mask_wr;
    logic [2:0]  mask_data;
    logic        irq_general, irq_l5, irq_l6, irq_l7, irq_nmi;
    logic [7:0]  bus_data;
    logic        inta, vec_valid, push_pc;
    logic [15:0] vec_addr;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .instr_boundary(instr_boundary), .ie_set(ie_set),
        .ie_clr(ie_clr), .mask_wr(mask_wr), .mask_data(mask_data),
        .irq_general(irq_general), .irq_l5(irq_l5), .irq_l6(irq_l6),
        .irq_l7(irq_l7), .irq_nmi(irq_nmi), .bus_data(bus_data),
        .inta(inta), .vec_valid(vec_valid), .vec_addr(vec_addr), .push_pc(push_pc)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] bytes [3];
    int bidx = 0;

    always @(negedge clk) begin
        if (inta) begin
            bus_data = bytes[(bidx < 3) ? bidx : 2];
            bidx++;
        end
    end

    bit       m_ie;
    bit [2:0] m_mask;
    bit       m_l7;

    int ob_inta, ob_vec, ob_push, ob_first;
    logic [15:0] ob_addr;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe(int n, bit fire);
        ob_inta = 0; ob_vec = 0; ob_push = 0; ob_first = -1; ob_addr = '0;
        bidx = 0;
        instr_boundary = fire;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) instr_boundary = 1'b0;
            if (inta) ob_inta++;
            if (push_pc) ob_push++;
            if (vec_valid) begin
                ob_vec++;
                ob_addr = vec_addr;
                if (ob_first < 0) ob_first = i;
            end
        end
    endtask

    task automatic expect_none(string req);
        observe(8, 1'b1);
        check({req, " no vector"}, ob_vec, 0);
        check({req, " no strobe"}, ob_inta, 0);
    endtask

    task automatic expect_hw(string req, logic [15:0] addr);
        observe(8, 1'b1);
        check({req, " vector"}, ob_addr, addr);
        check({req, " one vector cycle"}, ob_vec, 1);
        check({req, " push with vector"}, ob_push, 1);
        check({req, " vector timing"}, ob_first, 1);
        check({req, " no strobe"}, ob_inta, 0);
    endtask

    task automatic set_ie(bit v);
        @(negedge clk); ie_set = v; ie_clr = !v;
        @(negedge clk); ie_set = 1'b0; ie_clr = 1'b0;
        m_ie = v;
    endtask

    task automatic set_mask(bit [2:0] m);
        @(negedge clk); mask_wr = 1'b1; mask_data = m;
        @(negedge clk); mask_wr = 1'b0;
        m_mask = m;
    endtask

    task automatic pulse_l7();
        @(negedge clk); irq_l7 = 1'b1;
        @(negedge clk); irq_l7 = 1'b0;
        m_l7 = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_ie = 1'b0; m_mask = 3'b111; m_l7 = 1'b0;
    endtask

    function automatic int pick(bit tp, bit ie, bit [2:0] m, bit l7, bit l6,
                                bit l5, bit gi);
        if (tp) return 5;
        if (ie && !m[2] && l7) return 4;
        if (ie && !m[1] && l6) return 3;
        if (ie && !m[0] && l5) return 2;
        if (ie && gi) return 1;
        return 0;
    endfunction

    function automatic logic [15:0] hw_vec(int s);
        case (s)
            5: return 16'h0024;
            4: return 16'h003C;
            3: return 16'h0034;
            2: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; instr_boundary = 1'b0; ie_set = 1'b0; ie_clr = 1'b0;
        mask_wr = 1'b0; mask_data = 3'b000; irq_general = 1'b0; irq_l5 = 1'b0;
        irq_l6 = 1'b0; irq_l7 = 1'b0; irq_nmi = 1'b0; bus_data = 8'h00;
        bytes[0] = 8'h00; bytes[1] = 8'h00; bytes[2] = 8'h00;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state
        check("R1 inta after reset", inta, 0);
        check("R1 vec_valid after reset", vec_valid, 0);
        check("R1 push after reset", push_pc, 0);
        check("R1 vec_addr after reset", vec_addr, 0);
        irq_l5 = 1'b1; irq_l6 = 1'b1; irq_general = 1'b1;
        settle();
        expect_none("R1 enable off");
        irq_general = 1'b0;
        set_ie(1'b1);
        settle();
        expect_none("R6 masks set at reset");
        irq_l5 = 1'b0; irq_l6 = 1'b0;

        // R4 non-maskable with enable off
        do_reset();
        irq_nmi = 1'b1; settle();
        expect_hw("R4 trap", 16'h0024);
        expect_none("R4 trap needs new edge");
        irq_nmi = 1'b0; settle();
        irq_nmi = 1'b1; @(negedge clk); irq_nmi = 1'b0; settle();
        expect_none("R4 trap dropped before boundary");

        // R12 and R5
        set_ie(1'b1); set_mask(3'b000);
        irq_l5 = 1'b1;
        observe(6, 1'b0);
        check("R12 no service without boundary", ob_vec, 0);
        expect_hw("R3 level5", 16'h002C);
        expect_none("R5 enable cleared on accept");
        set_ie(1'b1); set_ie(1'b0); settle();
        expect_none("R5 disable blocks");
        irq_l5 = 1'b0;

        // R5 trap keeps enable
        set_ie(1'b1); set_mask(3'b111);
        irq_l5 = 1'b1;
        irq_nmi = 1'b1; settle();
        expect_hw("R5 trap over masked", 16'h0024);
        irq_nmi = 1'b0;
        set_mask(3'b000); settle();
        expect_hw("R5 enable kept after trap", 16'h002C);
        irq_l5 = 1'b0;

        // R7 edge latch survives mask
        set_ie(1'b1); set_mask(3'b100);
        pulse_l7(); settle();
        expect_none("R7 masked latch");
        set_mask(3'b000); settle();
        expect_hw("R7 latched edge", 16'h003C);
        set_ie(1'b1); settle();
        expect_none("R7 latch cleared");

        // R2 priority ladder
        do_reset();
        set_ie(1'b1); set_mask(3'b000);
        pulse_l7();
        irq_l5 = 1'b1; irq_l6 = 1'b1; irq_general = 1'b1; irq_nmi = 1'b1;
        bytes[0] = 8'hFF;
        settle();
        expect_hw("R2 trap first", 16'h0024);
        expect_hw("R2 level7 second", 16'h003C);
        set_ie(1'b1); settle();
        expect_hw("R2 level6 third", 16'h0034);
        irq_l6 = 1'b0;
        set_ie(1'b1); settle();
        expect_hw("R2 level5 fourth", 16'h002C);
        irq_l5 = 1'b0; irq_nmi = 1'b0;
        set_ie(1'b1); settle();
        observe(8, 1'b1);
        check("R2 general last", ob_addr, 16'h0038);

        // R8 restart
        set_ie(1'b1); bytes[0] = 8'hEF; settle();
        observe(8, 1'b1);
        check("R8 restart vector", ob_addr, 16'h0028);
        check("R8 single strobe", ob_inta, 1);
        check("R11 restart timing", ob_first, 2);
        check("R11 restart push", ob_push, 1);

        // R9 call
        set_ie(1'b1);
        bytes[0] = 8'hCD; bytes[1] = 8'h34; bytes[2] = 8'h12; settle();
        observe(10, 1'b1);
        check("R9 call target", ob_addr, 16'h1234);
        check("R9 three strobes", ob_inta, 3);
        check("R11 call timing", ob_first, 6);
        check("R11 call push", ob_push, 1);

        // R10 other opcode
        set_ie(1'b1); bytes[0] = 8'h76; settle();
        observe(8, 1'b1);
        check("R10 no vector", ob_vec, 0);
        check("R10 no push", ob_push, 0);
        check("R10 one strobe", ob_inta, 1);
        irq_general = 1'b0;

        // Random trials, R2 R3 R8 R9 R10
        do_reset();
        for (int it = 0; it < 400; it++) begin
            logic [31:0] r;
            logic [31:0] r2;
            bit tp;
            int kind;
            int exp_src;
            logic [15:0] call_t;
            r  = $urandom;
            r2 = $urandom;
            if (r[0]) set_ie(r[1]);
            if (r[2]) set_mask(r[5:3]);
            if (r[6] && r[7]) pulse_l7();
            @(negedge clk);
            irq_l5 = r[8]; irq_l6 = r[9]; irq_general = r[10];
            tp = r[11] & r[12];
            irq_nmi = tp;
            kind = int'(r[14:13]);
            call_t = r2[15:0];
            if (kind < 2) bytes[0] = {2'b11, r[17:15], 3'b111};
            else if (kind == 2) begin
                bytes[0] = 8'hCD; bytes[1] = call_t[7:0]; bytes[2] = call_t[15:8];
            end else bytes[0] = 8'h00;
            settle();
            exp_src = pick(tp, m_ie, m_mask, m_l7, irq_l6, irq_l5, irq_general);
            observe(9, 1'b1);
            if (exp_src == 0) begin
                check("R2 random none", ob_vec, 0);
            end else if (exp_src >= 2) begin
                check("R3 random vector", ob_addr, hw_vec(exp_src));
                check("R11 random timing", ob_first, 1);
            end else if (kind < 2) begin
                check("R8 random restart", ob_addr, {10'd0, r[17:15], 3'b000});
                check("R8 random strobes", ob_inta, 1);
            end else if (kind == 2) begin
                check("R9 random call", ob_addr, call_t);
                check("R9 random strobes", ob_inta, 3);
            end else begin
                check("R10 random invalid", ob_vec, 0);
            end
            if (exp_src >= 1 && exp_src <= 4) m_ie = 1'b0;
            if (exp_src == 4) m_l7 = 1'b0;
            irq_l5 = 1'b0; irq_l6 = 1'b0; irq_general = 1'b0; irq_nmi = 1'b0;
            @(negedge clk);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule